// File: doc/BRIEF.md
# Converter Serial Configuration Port with Pin-Strap Fallback

This block is the control port of a data converter. It runs on a system clock and samples three serial pins through a short synchronizer: an active-low chip select, a serial clock and one data line. The data line is split into an input, an output and an output enable, so the pad is built outside the block. A transaction begins with a 16-bit instruction. Its top bit picks read or write, the next two bits give the byte count and the low 13 bits give the starting register address. One or more bytes follow, and the address steps downward after each byte. Writes land in a shadow register file. The control register takes effect only when a 1 is written to the low bit of a dedicated transfer address.

A board that never drives the serial port ties chip select high. In that case the block reads its configuration from pins. The data pin sets the duty-cycle stabilizer enable and the clock pin sets the output format. Two extra strap pins set output high-impedance and power-down. Strap control lasts from reset until chip select is first seen low. From then until the next reset, the four control outputs come from the active control register.

The serial clock must stay high for at least four system clock cycles and low for at least four. Register 0 is the control register and holds the four control bits. Its reset value is 0x01. Registers 1 to NREGS-1 are general-purpose bytes.

Top module: `cfg_port_slave`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with the strap pins at their defaults, dcs_en=1, fmt_twos=0, out_hiz=0, pwr_down=0 and sdio_oe=0.
- R2: Until chip select has been seen low after reset, dcs_en follows the sdio_i level and fmt_twos follows the sclk level. out_hiz follows strap_oe and pwr_down follows strap_pd. High means asserted on all four.
- R3: Once chip select has been seen low, the control outputs come from the active control register. dcs_en is bit 0, fmt_twos bit 1, out_hiz bit 2 and pwr_down bit 3. Strap pin levels then have no effect until the next reset.
- R4: The instruction is 16 bits, sampled on rising sclk edges, MSB first. Bit 15 is read (1) or write (0), bits 14:13 are the byte count and bits 12:0 are the address.
- R5: A byte count of 00, 01 or 10 moves one, two or three data bytes, each MSB first. Any further bytes are ignored until chip select rises.
- R6: A byte count of 11 moves bytes until chip select rises.
- R7: The register address decreases by one after every data byte.
- R8: On a read, sdio_oe rises and sdio_o changes on falling sclk edges, starting with the falling edge after the 16th instruction bit. sdio_oe stays low during writes. A read returns the shadow value, and any address at or above NREGS reads as 0x00.
- R9: A write changes only the shadow copy. Writing a byte with bit 0 set to address 0x0FF copies the shadow control register into the active copy. A byte with bit 0 clear at that address does nothing.
- R10: A rising chip select aborts the transfer at any point. A partial byte is discarded, including one whose eighth rising sclk edge arrives in the same cycle as the chip-select rise. sdio_oe drops and the next transaction starts with an instruction.
- R11: Writes to addresses at or above NREGS change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; output-format strap in strap mode |
| sdio_i | input | 1 | Serial data in; stabilizer-enable strap in strap mode |
| sdio_o | output | 1 | Serial read data |
| sdio_oe | output | 1 | Drive enable for the serial data pad |
| strap_oe | input | 1 | Output high-impedance strap |
| strap_pd | input | 1 | Power-down strap |
| dcs_en | output | 1 | Duty-cycle stabilizer enable |
| fmt_twos | output | 1 | Two's complement output format |
| out_hiz | output | 1 | Converter outputs high-impedance |
| pwr_down | output | 1 | Power-down or standby |

## Verification
A chip-select rise and the eighth rising clock edge of a byte can reach the shift logic in the same system clock cycle. When they collide, the abort must win. The bench sets sclk and cs_n high in the same time step, so both pass through identical synchronizer stages and arrive together. It then reads the target register back through a fresh transaction and expects the value from before the aborted write. A second collision is between the strap path and the first serial activity. The bench raises the strap pins before the first transaction and checks that the outputs switch to the register value and ignore the straps.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;
  localparam int CTL_BITS = 4;
  localparam int CTL_DCS  = 0;
  localparam int CTL_TWOS = 1;
  localparam int CTL_HIZ  = 2;
  localparam int CTL_PD   = 3;
  localparam logic [1:0] WC_STREAM = 2'b11;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_serial_engine.sv
module cfg_serial_engine
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              oe
);
  localparam int IW = 3 + ADDR_W;
  localparam int CW = $clog2(IW + 1);
  localparam int BW = $clog2(DATA_W);

  phase_t            ph;
  logic              sclk_q;
  logic [IW-2:0]     isr;
  logic [CW-1:0]     icnt;
  logic              rw;
  logic [1:0]        wc;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-2:0] rsr;
  logic [DATA_W-1:0] tsr;
  logic [1:0]        nbyte;

  wire          rise  = sclk_s & ~sclk_q;
  wire          fall  = ~sclk_s & sclk_q;
  wire [IW-1:0] iword = {isr, din_s};

  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_INSTR; sclk_q <= 1'b0; isr <= '0; icnt <= '0; rw <= 1'b0;
      wc <= '0; addr_q <= '0; bcnt <= '0; rsr <= '0; tsr <= '0; nbyte <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; dout <= 1'b0; oe <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      wr_en  <= 1'b0;
      if (cs_s) begin
        ph   <= PH_INSTR;
        icnt <= '0;
        bcnt <= '0;
        oe   <= 1'b0;
      end else begin
        case (ph)
          PH_INSTR: if (rise) begin
            isr <= iword[IW-2:0];
            if (icnt == CW'(IW - 1)) begin
              rw     <= iword[IW-1];
              wc     <= iword[IW-2 -: 2];
              addr_q <= iword[ADDR_W-1:0];
              ph     <= PH_DATA;
              icnt   <= '0;
              bcnt   <= '0;
              nbyte  <= '0;
            end else begin
              icnt <= icnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (fall && rw) begin
              oe <= 1'b1;
              if (bcnt == '0) begin
                dout <= rd_data[DATA_W-1];
                tsr  <= {rd_data[DATA_W-2:0], 1'b0};
              end else begin
                dout <= tsr[DATA_W-1];
                tsr  <= {tsr[DATA_W-2:0], 1'b0};
              end
            end
            if (rise) begin
              rsr <= {rsr[DATA_W-3:0], din_s};
              if (bcnt == BW'(DATA_W - 1)) begin
                bcnt <= '0;
                if (!rw) begin
                  wr_en   <= 1'b1;
                  wr_addr <= addr_q;
                  wr_data <= {rsr, din_s};
                end
                addr_q <= addr_q - 1'b1;
                nbyte  <= nbyte + 1'b1;
                if (wc != WC_STREAM && nbyte == wc) ph <= PH_DONE;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end
          default: if (fall) oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int NREGS = 4,
  parameter int unsigned XFER_ADDR = 'h0FF,
  parameter logic [DATA_W-1:0] CTRL_RST = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                xfer,
  output logic [CTL_BITS-1:0] act_ctl
);
  localparam int IXW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DATA_W-1:0] shadow [NREGS];

  wire rd_hit = rd_addr < ADDR_W'(NREGS);
  wire wr_hit = wr_addr < ADDR_W'(NREGS);

  assign rd_data = rd_hit ? shadow[rd_addr[IXW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) shadow[i] <= (i == 0) ? CTRL_RST : '0;
      xfer    <= 1'b0;
      act_ctl <= CTRL_RST[CTL_BITS-1:0];
    end else begin
      if (wr_en && wr_hit) shadow[wr_addr[IXW-1:0]] <= wr_data;
      xfer <= wr_en && (wr_addr == ADDR_W'(XFER_ADDR)) && wr_data[0];
      if (xfer) act_ctl <= shadow[0][CTL_BITS-1:0];
    end
  end
endmodule

// File: rtl/cfg_mode_select.sv
module cfg_mode_select
  import cfg_port_pkg::*;
#(
  parameter logic [CTL_BITS-1:0] RST_CTL = 4'b0001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_s,
  input  logic [CTL_BITS-1:0] strap_s,
  input  logic [CTL_BITS-1:0] reg_ctl,
  output logic                spi_used,
  output logic [CTL_BITS-1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      spi_used <= 1'b0;
      ctl_q    <= RST_CTL;
    end else begin
      if (!cs_s) spi_used <= 1'b1;
      for (int b = 0; b < CTL_BITS; b++)
        ctl_q[b] <= spi_used ? reg_ctl[b] : strap_s[b];
    end
  end
endmodule

// File: rtl/cfg_port_slave.sv
module cfg_port_slave
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int NREGS = 4,
  parameter int unsigned XFER_ADDR = 'h0FF,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CTRL_RST = 8'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  input  logic strap_oe,
  input  logic strap_pd,
  output logic dcs_en,
  output logic fmt_twos,
  output logic out_hiz,
  output logic pwr_down
);
  localparam int NPINS = 5;

  logic [NPINS-1:0]    pins_s;
  logic                cs_s, sclk_s, din_s, oe_s, pd_s;
  logic [CTL_BITS-1:0] strap_s;
  logic [ADDR_W-1:0]   rd_addr, wr_addr;
  logic [DATA_W-1:0]   rd_data, wr_data;
  logic                wr_en, xfer, spi_used;
  logic [CTL_BITS-1:0] act_ctl, ctl_q;

  cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(NPINS), .RST_VAL(5'b10100)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, sclk, sdio_i, strap_oe, strap_pd}),
    .q(pins_s)
  );

  assign {cs_s, sclk_s, din_s, oe_s, pd_s} = pins_s;

  always_comb begin
    strap_s           = '0;
    strap_s[CTL_DCS]  = din_s;
    strap_s[CTL_TWOS] = sclk_s;
    strap_s[CTL_HIZ]  = oe_s;
    strap_s[CTL_PD]   = pd_s;
  end

  cfg_serial_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_s(sclk_s), .din_s(din_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout(sdio_o), .oe(sdio_oe)
  );

  cfg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS),
    .XFER_ADDR(XFER_ADDR), .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer(xfer), .act_ctl(act_ctl)
  );

  cfg_mode_select #(.RST_CTL(CTRL_RST[CTL_BITS-1:0])) u_mode (
    .clk(clk), .rst(rst), .cs_s(cs_s), .strap_s(strap_s),
    .reg_ctl(act_ctl), .spi_used(spi_used), .ctl_q(ctl_q)
  );

  assign dcs_en   = ctl_q[CTL_DCS];
  assign fmt_twos = ctl_q[CTL_TWOS];
  assign out_hiz  = ctl_q[CTL_HIZ];
  assign pwr_down = ctl_q[CTL_PD];
endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker
  import cfg_port_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cs_s,
  input logic                wr_en,
  input logic                oe,
  input logic                xfer,
  input logic                spi_used,
  input logic [CTL_BITS-1:0] act_ctl,
  input logic [CTL_BITS-1:0] strap_s,
  input logic [CTL_BITS-1:0] ctl_q
);
  // R10: an idle or aborting select releases the data pad
  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !oe);

  // R8: the pad is never driven while a write byte is committed
  assert_no_drive_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !oe);

  // R9: the active control copy moves only after a transfer strobe
  assert_active_on_xfer_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_ctl) |-> $past(xfer));

  // R2: strap mode passes the synchronized pin levels through
  assert_strap_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !spi_used |=> ctl_q == $past(strap_s));

  // R3: register mode is sticky and shows the active control copy
  assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    spi_used |=> spi_used);

  assert_reg_out_R3: assert property (@(posedge clk) disable iff (rst)
    spi_used |=> ctl_q == $past(act_ctl));
endmodule

bind cfg_port_slave cfg_port_checker u_cfg_port_checker (
  .clk(clk), .rst(rst), .cs_s(cs_s), .wr_en(wr_en), .oe(sdio_oe),
  .xfer(xfer), .spi_used(spi_used), .act_ctl(act_ctl),
  .strap_s(strap_s), .ctl_q(ctl_q)
);

// File: tb/cfg_port_slave_bench.sv
module cfg_port_slave_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b1, strap_oe = 1'b0, strap_pd = 1'b0;
  logic sdio_o, sdio_oe, dcs_en, fmt_twos, out_hiz, pwr_down;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic oe_any, oe_first;

  // stimulus [7:4] = {sdio_i, sclk, strap_oe, strap_pd}; expected [3:0] = {pd, hiz, twos, dcs}
  localparam logic [7:0] STRAP_VEC [7] = '{8'h81, 8'h00, 8'h42, 8'h24, 8'h18, 8'hFF, 8'h66};

  cfg_port_slave u_cfg_port_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .strap_oe(strap_oe), .strap_pd(strap_pd),
    .dcs_en(dcs_en), .fmt_twos(fmt_twos), .out_hiz(out_hiz), .pwr_down(pwr_down)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] outs();
    return {pwr_down, out_hiz, fmt_twos, dcs_en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    sdio_i = b;
    repeat (H) @(negedge clk);
    r = sdio_o;
    if (sdio_oe) oe_any = 1'b1;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_txn(input logic rw, input logic [1:0] wc, input logic [12:0] addr, input int nbytes);
    logic [15:0] word;
    logic r;
    word = {rw, wc, addr};
    oe_any = 1'b0;
    oe_first = 1'b0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 15; i >= 0; i--) bit_cycle(word[i], r);
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_cycle(rw ? 1'b0 : wbuf[b][i], r);
        rbuf[b][i] = r;
        if (b == 0 && i == 7) oe_first = sdio_oe;
      end
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic wr1(input logic [12:0] addr, input logic [7:0] d);
    wbuf[0] = d;
    spi_txn(1'b0, 2'b00, addr, 1);
  endtask

  task automatic rd1(input logic [12:0] addr);
    spi_txn(1'b1, 2'b00, addr, 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic r;
    repeat (5) @(negedge clk);
    chk("R1 outputs in reset", outs(), 4'h1);
    chk("R1 oe in reset", sdio_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", outs(), 4'h1);
    chk("R1 oe after reset", sdio_oe, 1'b0);

    // strap table, chip select held high
    foreach (STRAP_VEC[k]) begin
      {sdio_i, sclk, strap_oe, strap_pd} = STRAP_VEC[k][7:4];
      repeat (10) @(negedge clk);
      chk($sformatf("R2 strap vector %0d", k), outs(), STRAP_VEC[k][3:0]);
    end

    // leave straps high; first transaction must switch to register control
    sclk = 1'b0; sdio_i = 1'b0; strap_oe = 1'b1; strap_pd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 straps high before select", outs(), 4'hC);
    wr1(13'h0000, 8'h0E);
    chk("R3 register control ignores straps", outs(), 4'h1);
    chk("R9 shadow write leaves outputs", outs(), 4'h1);
    chk("R8 no drive during write", oe_any, 1'b0);
    rd1(13'h0000);
    chk("R4 R8 read shadow control", rbuf[0], 8'h0E);
    chk("R8 oe on first read bit", oe_first, 1'b1);

    wr1(13'h00FF, 8'h01);
    chk("R9 transfer applies control", outs(), 4'hE);

    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    spi_txn(1'b0, 2'b01, 13'h0002, 2);
    spi_txn(1'b1, 2'b01, 13'h0002, 2);
    chk("R5 R7 two-byte byte 0", rbuf[0], 8'hA5);
    chk("R5 R7 two-byte byte 1", rbuf[1], 8'h3C);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h04;
    spi_txn(1'b0, 2'b11, 13'h0003, 4);
    spi_txn(1'b1, 2'b11, 13'h0003, 4);
    for (int k = 0; k < 4; k++)
      chk($sformatf("R6 stream byte %0d", k), rbuf[k], wbuf[k]);
    chk("R9 outputs unchanged by stream", outs(), 4'hE);

    wbuf[0] = 8'h5A; wbuf[1] = 8'hFF;
    spi_txn(1'b0, 2'b00, 13'h0001, 2);
    spi_txn(1'b1, 2'b01, 13'h0001, 2);
    chk("R5 single byte written", rbuf[0], 8'h5A);
    chk("R5 extra byte ignored", rbuf[1], 8'h04);

    // R10 abort within a data byte
    w = {1'b0, 2'b00, 13'h0002};
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 15; i >= 0; i--) bit_cycle(w[i], r);
    for (int i = 7; i >= 3; i--) bit_cycle(1'b1, r);
    cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
    rd1(13'h0002);
    chk("R10 partial byte discarded", rbuf[0], 8'h22);

    // R10 abort within the instruction
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 7; i++) bit_cycle(1'b1, r);
    cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
    rd1(13'h0003);
    chk("R10 fresh instruction after abort", rbuf[0], 8'h11);

    // R10 select rise coincides with eighth rising edge
    w = {1'b0, 2'b00, 13'h0001};
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 15; i >= 0; i--) bit_cycle(w[i], r);
    for (int i = 7; i >= 1; i--) bit_cycle(1'b1, r);
    sdio_i = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (3 * H) @(negedge clk);
    chk("R10 oe low after collision", sdio_oe, 1'b0);
    rd1(13'h0001);
    chk("R10 colliding byte discarded", rbuf[0], 8'h5A);

    wr1(13'h0100, 8'h99);
    rd1(13'h0100);
    chk("R8 R11 unmapped reads zero", rbuf[0], 8'h00);
    rd1(13'h00FF);
    chk("R8 transfer address reads zero", rbuf[0], 8'h00);
    rd1(13'h0000);
    chk("R11 no alias onto control", rbuf[0], 8'h04);

    wr1(13'h00FF, 8'h02);
    chk("R9 transfer bit clear no effect", outs(), 4'hE);
    wr1(13'h00FF, 8'h01);
    chk("R9 second transfer applies", outs(), 4'h4);

    strap_oe = 1'b0; strap_pd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 strap change ignored", outs(), 4'h4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule